// File: doc/BRIEF.md
# Cascaded Hours-Minutes-Seconds Time Counter

This block keeps time of day as three chained digit stages: seconds (modulo 60), minutes (modulo 60) and hours (modulo 24). A single tick input, normally pulsed once per second, advances the seconds stage.

Each stage raises a rollover output during the cycle in which it is at its top value and is told to advance. That rollover is the advance input of the next stage. All stages share one clock, so a carry through all three stages lands on a single edge and no stage is clocked by another stage's output.

The rollover of the hours stage leaves the block as a one-cycle day pulse. A synchronous clear input returns the whole chain to 00:00:00.

Top module: `hms_clock`

## Requirements
- R1: While the reset input is low and for the two clock edges after it is released, the block reports 00:00:00 with the day pulse low.
- R2: On an edge where both tick and clear are low, seconds, minutes and hours keep their values.
- R3: On an edge where tick is high and clear is low, seconds goes up by one if it is below 59.
- R4: On a ticked edge where seconds is 59, seconds becomes 0 and minutes goes up by one on that same edge.
- R5: On a ticked edge at seconds 59 and minutes 59, both become 0 and hours goes up by one on that same edge.
- R6: On a ticked edge at 23:59:59, all three fields become 0 together, and the day pulse is high during that cycle.
- R7: On an edge where clear is high and tick is low, all three fields become 0.
- R8: When clear and tick are high together, clear wins: all fields become 0 and no rollover or day pulse is raised.
- R9: The day pulse is combinational. It is high exactly when tick is high, clear is low and the time is 23:59:59. Seconds never exceeds 59, minutes never exceeds 59 and hours never exceeds 23.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all stages |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous clear to 00:00:00, overrides tick |
| inc | input | 1 | Advance tick for the seconds stage |
| seconds | output | 6 | Seconds field, 0 to 59 |
| minutes | output | 6 | Minutes field, 0 to 59 |
| hours | output | 5 | Hours field, 0 to 23 |
| day_tick | output | 1 | High during the cycle of the 23:59:59 to 00:00:00 carry |

## Verification
Two functions can fall in the same cycle: a carry through the stages and a clear. Counting into a carry boundary and then asserting clear together with tick, in the exact cycle where a rollover would otherwise start, provokes the collision. The result is judged by requiring 00:00:00 on the next edge, with no minute advance and no day pulse.

The bench also sweeps a full day with occasional tick gaps. An arithmetic model of elapsed seconds gives the expected fields and day pulse for every cycle, including the three-stage carry at midnight and the terminal state held without tick.

// File: rtl/hms_pkg.sv
package hms_pkg;

  // Bits needed to hold values 0 .. modulus-1
  function automatic int digit_width(input int modulus);
    int w;
    w = $clog2(modulus);
    if (w < 1) w = 1;
    return w;
  endfunction

endpackage

// File: rtl/hms_rst_sync.sv
module hms_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/hms_digit.sv
module hms_digit #(
  parameter int MODULUS = 60,
  parameter int WIDTH   = hms_pkg::digit_width(MODULUS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [WIDTH-1:0] value,
  output logic             roll
);

  localparam logic [WIDTH-1:0] TOP = WIDTH'(MODULUS - 1);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] value_q;
  logic [WIDTH-1:0] value_d;
  logic             at_top;
  logic             load_en;

  assign at_top  = (value_q == TOP);
  assign load_en = clr | inc;

  // Next-state logic: clear has precedence over advance
  always_comb begin
    value_d = value_q;
    if (clr) begin
      value_d = '0;
    end else if (inc) begin
      value_d = at_top ? '0 : (value_q + ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
    end else if (load_en) begin
      value_q <= value_d;
    end
  end

  // Mealy carry: only while advancing from the top value
  assign roll  = inc & ~clr & at_top;
  assign value = value_q;

endmodule

// File: rtl/hms_clock.sv
module hms_clock #(
  parameter int SEC_MOD = 60,
  parameter int MIN_MOD = 60,
  parameter int HR_MOD  = 24,
  localparam int SEC_W  = hms_pkg::digit_width(SEC_MOD),
  localparam int MIN_W  = hms_pkg::digit_width(MIN_MOD),
  localparam int HR_W   = hms_pkg::digit_width(HR_MOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [SEC_W-1:0] seconds,
  output logic [MIN_W-1:0] minutes,
  output logic [HR_W-1:0]  hours,
  output logic             day_tick
);

  logic rst_core_n;
  logic sec_roll;
  logic min_roll;
  logic hr_roll;

  hms_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  hms_digit #(.MODULUS(SEC_MOD), .WIDTH(SEC_W)) u_sec (
    .clk   (clk),
    .rst_n (rst_core_n),
    .clr   (clr),
    .inc   (inc),
    .value (seconds),
    .roll  (sec_roll)
  );

  hms_digit #(.MODULUS(MIN_MOD), .WIDTH(MIN_W)) u_min (
    .clk   (clk),
    .rst_n (rst_core_n),
    .clr   (clr),
    .inc   (sec_roll),
    .value (minutes),
    .roll  (min_roll)
  );

  hms_digit #(.MODULUS(HR_MOD), .WIDTH(HR_W)) u_hr (
    .clk   (clk),
    .rst_n (rst_core_n),
    .clr   (clr),
    .inc   (min_roll),
    .value (hours),
    .roll  (hr_roll)
  );

  assign day_tick = hr_roll;

endmodule

// File: rtl/hms_clock_checker.sv
module hms_clock_checker #(
  parameter int SEC_MOD = 60,
  parameter int MIN_MOD = 60,
  parameter int HR_MOD  = 24,
  parameter int SEC_W   = 6,
  parameter int MIN_W   = 6,
  parameter int HR_W    = 5
) (
  input logic             clk,
  input logic             rst_core_n,
  input logic             clr,
  input logic             inc,
  input logic [SEC_W-1:0] seconds,
  input logic [MIN_W-1:0] minutes,
  input logic [HR_W-1:0]  hours,
  input logic             day_tick
);

  AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (seconds < SEC_W'(SEC_MOD)) && (minutes < MIN_W'(MIN_MOD)) && (hours < HR_W'(HR_MOD))); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!inc && !clr) |=> $stable({hours, minutes, seconds})); // R2

  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_core_n)
    (inc && !clr && seconds != SEC_W'(SEC_MOD - 1)) |=> (seconds == SEC_W'($past(seconds) + 1'b1))); // R3

  AST_SEC_CARRY: assert property (@(posedge clk) disable iff (!rst_core_n)
    (inc && !clr && seconds == SEC_W'(SEC_MOD - 1) && minutes != MIN_W'(MIN_MOD - 1))
    |=> (seconds == '0 && minutes == MIN_W'($past(minutes) + 1'b1))); // R4

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_core_n)
    clr |=> (seconds == '0 && minutes == '0 && hours == '0)); // R7

  AST_CLEAR_NO_DAY: assert property (@(posedge clk) disable iff (!rst_core_n)
    clr |-> !day_tick); // R8

  AST_DAY_CAUSE: assert property (@(posedge clk) disable iff (!rst_core_n)
    day_tick |-> (inc && seconds == SEC_W'(SEC_MOD - 1) && minutes == MIN_W'(MIN_MOD - 1)
                  && hours == HR_W'(HR_MOD - 1))); // R6

  AST_DAY_WRAP: assert property (@(posedge clk) disable iff (!rst_core_n)
    day_tick |=> (seconds == '0 && minutes == '0 && hours == '0)); // R6

endmodule

bind hms_clock hms_clock_checker #(
  .SEC_MOD(SEC_MOD), .MIN_MOD(MIN_MOD), .HR_MOD(HR_MOD),
  .SEC_W(SEC_W), .MIN_W(MIN_W), .HR_W(HR_W)
) u_hms_clock_checker (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .clr        (clr),
  .inc        (inc),
  .seconds    (seconds),
  .minutes    (minutes),
  .hours      (hours),
  .day_tick   (day_tick)
);

// File: tb/tb_hms_clock.sv
module tb_hms_clock;

  localparam int CLK_PERIOD = 10;
  localparam int DAY_SECS   = 86400;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       clr;
  logic       inc;
  logic [5:0] seconds;
  logic [5:0] minutes;
  logic [4:0] hours;
  logic       day_tick;

  int  checks = 0;
  int  bad    = 0;
  int  t      = 0;
  bit  done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hms_clock dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .inc      (inc),
    .seconds  (seconds),
    .minutes  (minutes),
    .hours    (hours),
    .day_tick (day_tick)
  );

  // Compare all outputs against the elapsed-seconds model
  task automatic check_now(input string tag);
    logic [17:0] exp_v;
    logic [17:0] act_v;
    bit          exp_day;
    exp_day = inc && !clr && (t == DAY_SECS - 1);
    exp_v   = {5'(t / 3600), 6'((t / 60) % 60), 6'(t % 60), exp_day};
    act_v   = {hours, minutes, seconds, day_tick};
    checks++;
    if (act_v !== exp_v) begin
      bad++;
      $display("FAIL %s: actual %0d:%0d:%0d day=%0b expected %0d:%0d:%0d day=%0b",
               tag, hours, minutes, seconds, day_tick,
               t / 3600, (t / 60) % 60, t % 60, exp_day);
    end
  endtask

  // Drive at the falling edge, check, then advance the model at the rising edge
  task automatic step(input bit c, input bit i, input string tag_in);
    string tag;
    @(negedge clk);
    clr = c;
    inc = i;
    #1;
    if (tag_in != "")           tag = tag_in;
    else if (c && i)            tag = "R8";
    else if (c)                 tag = "R7";
    else if (!i)                tag = "R2";
    else if (t == DAY_SECS - 1) tag = "R6";
    else if (t % 3600 == 3599)  tag = "R5";
    else if (t % 60 == 59)      tag = "R4";
    else                        tag = "R3";
    check_now(tag);
    @(posedge clk);
    if (c)      t = 0;
    else if (i) t = (t + 1) % DAY_SECS;
  endtask

  initial begin
    rst_n = 1'b0;
    clr   = 1'b0;
    inc   = 1'b0;
    repeat (3) @(negedge clk);
    #1 check_now("R1");
    rst_n = 1'b1;
    // Tick held high across the synchronizer window must be ignored (R1)
    @(negedge clk);
    inc = 1'b1;
    #1 check_now("R1");
    @(posedge clk);
    @(negedge clk);
    #1 check_now("R1");
    inc = 1'b0;
    @(posedge clk);
    step(1'b1, 1'b0, "R1");

    // Full-day sweep with periodic tick gaps
    for (int cyc = 0; t != DAY_SECS - 1; cyc++) begin
      step(1'b0, (cyc % 16) != 5, "");
    end
    // Terminal state without tick: no day pulse, hold (R9)
    step(1'b0, 1'b0, "R9");
    // Midnight carry through all stages (R6)
    step(1'b0, 1'b1, "R6");
    step(1'b0, 1'b0, "R6");

    // Clear alone after some progress (R7)
    for (int k = 0; k < 130; k++) step(1'b0, 1'b1, "");
    step(1'b1, 1'b0, "R7");
    step(1'b0, 1'b0, "R7");

    // Clear with tick at a seconds carry boundary (R8)
    for (int k = 0; k < 60 + 59; k++) step(1'b0, 1'b1, "");
    step(1'b1, 1'b1, "R8");
    step(1'b0, 1'b0, "R8");
    for (int k = 0; k < 5; k++) step(1'b0, 1'b1, "");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule